// File: doc/BRIEF.md
# Serial Peripheral Slave Front End with Hold Pause

This block is the serial front end of a small byte-wide memory. It watches the four serial pins (clock, data in, select, hold) from the system clock domain and delivers each complete received byte to a back end over a valid/ready stream. It takes bytes to transmit from the back end over a second valid/ready stream, and shifts them out most significant bit first with an enable that tri-states the output driver. Instruction decoding, storage and status live in the back end.

Both idle clock levels work: low in mode (0,0) and high in mode (1,1). A hold pin pauses a transfer without deselecting. It takes effect only while the serial clock is low. While paused, the output driver is off and clock edges are ignored. A power-up guard keeps the block deaf until chip select has been seen going from high to low.

Receive stream rules: `rx_valid` rises with a new byte and stays up until `rx_ready` is seen high. The serial side cannot be stalled, so a byte that completes while an older one is still waiting replaces it. Transmit stream rules: `tx_ready` is high only while the device is selected, at least one byte has been received in this selection, and the output shifter is empty. The back end must hand over a byte within half a serial clock period of that point.

Top module: `spi_hold_slave`

## Requirements
- R1: Received bits are taken MSB first on serial clock rising edges. After eight bits, `rx_data` holds the byte and `rx_valid` stays high until a cycle with `rx_ready` high. A later byte that completes before that handshake replaces the waiting one.
- R2: `bit_cnt` counts the rising edges of the current byte, 0 to 7, and wraps to 0. `byte_done` is a single-cycle pulse when the eighth bit arrives.
- R3: A byte accepted on the transmit stream appears on `spi_miso` MSB first. Its first bit is driven after the first serial clock falling edge that follows the acceptance, and each later bit after each later falling edge.
- R4: While deselected (`spi_cs_n` high), `spi_miso_oe` is 0, `tx_ready` is 0 and `bit_cnt` is 0.
- R5: If `spi_cs_n` is already low when reset ends, the block stays deselected and ignores the serial clock until `spi_cs_n` has gone high and then low.
- R6: A pause begins when `spi_hold_n` is low while the serial clock is low. It ends when `spi_hold_n` is high while the serial clock is low. A request made while the clock is high waits for the clock to be low.
- R7: During a pause, `spi_miso_oe` is 0, clock edges and data input are ignored, and `bit_cnt` is frozen. The byte in progress resumes at the bit where it stopped.
- R8: Raising `spi_cs_n`, including during a pause, discards any partial byte, clears the pause and returns `bit_cnt` to 0.
- R9: Transfers behave identically in mode (0,0) and mode (1,1). The leading falling edge in mode (1,1) does not shift out data before a byte has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the bus master |
| spi_mosi | input | 1 | Serial data into the device |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_hold_n | input | 1 | Active-low pause request |
| spi_miso | output | 1 | Serial data out of the device |
| spi_miso_oe | output | 1 | Output driver enable for spi_miso |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Back end takes the received byte |
| rx_data | output | 8 | Received byte |
| tx_valid | input | 1 | Back end offers a byte to send |
| tx_ready | output | 1 | Output shifter empty and allowed to load |
| tx_data | input | 8 | Byte to send |
| bit_cnt | output | 3 | Bits received in the current byte |
| byte_done | output | 1 | One-cycle pulse per completed byte |

## Verification
Write-style bursts of several bytes in mode (0,0) show MSB-first assembly and the byte count. A read burst adds the transmit path and a pause inside a byte, with clock and data toggled during the pause, so lost or extra edges would corrupt both directions. A mode (1,1) read with the pause requested while the clock is high separates deferred entry from immediate entry. Separate runs cover a select line that is low from power-up, a held-off receive stream where the second byte must replace the first, and deselection in the middle of a pause followed by a clean byte.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef struct packed {
    logic sck;
    logic mosi;
    logic cs_n;
    logic hold_n;
  } spi_pins_t;

  localparam int PIN_W = $bits(spi_pins_t);

  // cs_n resets low so a select already low at power-up never looks like a fall
  localparam spi_pins_t PINS_RST = '{sck: 1'b0, mosi: 1'b0, cs_n: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
  import spi_hold_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  spi_pins_t pins_raw,
  output spi_pins_t pins_sync
);
  localparam int CHAIN_W = STAGES * PIN_W;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{PINS_RST}};
    else        chain <= {chain[CHAIN_W-PIN_W-1:0], pins_raw};
  end

  assign pins_sync = chain[CHAIN_W-1 -: PIN_W];
endmodule

// File: rtl/spi_link_ctrl.sv
module spi_link_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  output logic sel,
  output logic held,
  output logic rise_ev,
  output logic fall_ev
);
  logic sck_q, cs_q, armed;
  logic cs_fall;

  assign cs_fall = cs_q & ~cs_n;
  assign sel     = (armed | cs_fall) & ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b0;
      armed <= 1'b0;
      held  <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_fall) armed <= 1'b1;
      if (!sel)      held <= 1'b0;
      else if (!sck) held <= ~hold_n;
    end
  end

  assign rise_ev = sel & ~held &  sck & ~sck_q;
  assign fall_ev = sel & ~held & ~sck &  sck_q;
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 rise_ev,
  input  logic                 mosi,
  input  logic                 rx_ready,
  output logic                 rx_valid,
  output logic [W-1:0]         rx_data,
  output logic [$clog2(W)-1:0] bit_cnt,
  output logic                 byte_done
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0] sh;
  logic [W-1:0] sh_next;

  assign sh_next = {sh[W-2:0], mosi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      bit_cnt   <= '0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (!sel) begin
        bit_cnt <= '0;
      end else if (rise_ev) begin
        sh <= sh_next;
        if (bit_cnt == LAST) begin
          bit_cnt   <= '0;
          rx_data   <= sh_next;
          rx_valid  <= 1'b1;
          byte_done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         held,
  input  logic         fall_ev,
  input  logic         byte_done,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_ready,
  output logic         so,
  output logic         so_oe
);
  localparam int LW = $clog2(W + 1);

  logic [W-1:0]  sh;
  logic [LW-1:0] left;
  logic          active, seen;

  assign tx_ready = sel & seen & (left == '0);
  assign so_oe    = sel & ~held & active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      left   <= '0;
      active <= 1'b0;
      seen   <= 1'b0;
      so     <= 1'b0;
    end else if (!sel) begin
      left   <= '0;
      active <= 1'b0;
      seen   <= 1'b0;
    end else begin
      if (byte_done) seen <= 1'b1;
      if (tx_valid && tx_ready) begin
        sh   <= tx_data;
        left <= LW'(W);
      end else if (fall_ev && left != '0) begin
        so     <= sh[W-1];
        sh     <= {sh[W-2:0], 1'b0};
        left   <= left - 1'b1;
        active <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
  import spi_hold_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sck,
  input  logic                 spi_mosi,
  input  logic                 spi_cs_n,
  input  logic                 spi_hold_n,
  output logic                 spi_miso,
  output logic                 spi_miso_oe,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [W-1:0]         rx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [W-1:0]         tx_data,
  output logic [$clog2(W)-1:0] bit_cnt,
  output logic                 byte_done
);
  spi_pins_t raw, syn;
  logic sel, held, rise_ev, fall_ev;

  assign raw = '{sck: spi_sck, mosi: spi_mosi, cs_n: spi_cs_n, hold_n: spi_hold_n};

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_raw(raw), .pins_sync(syn)
  );

  spi_link_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sck(syn.sck), .cs_n(syn.cs_n), .hold_n(syn.hold_n),
    .sel(sel), .held(held), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  spi_rx_shift #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rise_ev(rise_ev), .mosi(syn.mosi),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .bit_cnt(bit_cnt), .byte_done(byte_done)
  );

  spi_tx_shift #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .sel(sel), .held(held), .fall_ev(fall_ev),
    .byte_done(byte_done), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .so(spi_miso), .so_oe(spi_miso_oe)
  );
endmodule

// File: rtl/spi_hold_slave_chk.sv
module spi_hold_slave_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          held,
  input logic          so_oe,
  input logic          byte_done,
  input logic [CW-1:0] bit_cnt,
  input logic          tx_ready,
  input logic          rx_valid,
  input logic          rx_ready
);
  a_r1_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);
  a_r2_done_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> bit_cnt == '0);
  a_r4_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !so_oe && !tx_ready);
  a_r7_oe_off_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !so_oe);
  a_r7_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    held && $past(held) && sel |-> $stable(bit_cnt));
  a_r8_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !sel && $past(!sel) |-> bit_cnt == '0);
endmodule

bind spi_hold_slave spi_hold_slave_chk #(.CW($clog2(W))) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .held(held), .so_oe(spi_miso_oe),
  .byte_done(byte_done), .bit_cnt(bit_cnt), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready)
);

// File: tb/spi_hold_slave_test.sv
module spi_hold_slave_test;
  localparam int H = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b0, spi_hold_n = 1'b1;
  logic spi_miso, spi_miso_oe, rx_valid, tx_ready, byte_done;
  logic rx_ready = 1'b1, tx_valid = 1'b0;
  logic [7:0] rx_data, tx_data = 8'h00;
  logic [2:0] bit_cnt;

  int n_chk = 0, n_fail = 0, n_done = 0, exp_done = 0;
  bit cpol = 1'b0;
  logic [7:0] rx_q[$];
  logic [7:0] tx_q[$];

  always #4 clk = ~clk;

  spi_hold_slave uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_hold_n(spi_hold_n), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .bit_cnt(bit_cnt), .byte_done(byte_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard for the receive stream (R1) and pulse count (R2)
  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_done) n_done++;
      if (rx_valid && rx_ready) begin
        if (rx_q.size() == 0) chk(1'b0, "R1 unexpected byte", rx_data, 0);
        else begin
          logic [7:0] e;
          e = rx_q.pop_front();
          chk(rx_data == e, "R1 received byte", rx_data, e);
        end
      end
    end
  end

  // back end model for the transmit stream
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid) begin
        if (!tx_ready) tx_valid = 1'b0;
      end else if (tx_ready && tx_q.size() > 0) begin
        tx_data  = tx_q.pop_front();
        tx_valid = 1'b1;
      end
    end
  end

  task automatic do_hold(input int bits_done, input bit chk_mi);
    spi_hold_n = 1'b0;
    wait_cyc(H);
    if (cpol) begin
      if (chk_mi) chk(spi_miso_oe == 1'b1, "R6 pause deferred while clock high", spi_miso_oe, 1);
      chk(bit_cnt == 3'(bits_done), "R6 count before pause", bit_cnt, bits_done);
      spi_sck = 1'b0;
      wait_cyc(H);
    end
    if (chk_mi) chk(spi_miso_oe == 1'b0, "R7 driver off in pause", spi_miso_oe, 0);
    for (int k = 0; k < 3; k++) begin
      spi_sck = 1'b1; spi_mosi = ~spi_mosi; wait_cyc(4);
      spi_sck = 1'b0; wait_cyc(4);
    end
    wait_cyc(H);
    chk(bit_cnt == 3'(bits_done), "R7 count frozen in pause", bit_cnt, bits_done);
    spi_hold_n = 1'b1;
    wait_cyc(H);
    if (chk_mi) chk(spi_miso_oe == 1'b1, "R6 pause released", spi_miso_oe, 1);
  endtask

  // driver: one byte full duplex; pushes the expected receive item
  task automatic xfer(input logic [7:0] mo, input bit push_rx, input bit chk_mi,
                      input logic [7:0] exp_mi, input int hold_bit);
    logic [7:0] got;
    if (push_rx) rx_q.push_back(mo);
    exp_done++;
    for (int i = 7; i >= 0; i--) begin
      if (cpol) spi_sck = 1'b0;
      spi_mosi = mo[i];
      wait_cyc(H);
      got[i] = spi_miso;
      spi_sck = 1'b1;
      wait_cyc(H);
      if (!cpol) spi_sck = 1'b0;
      if (i == hold_bit) do_hold(8 - i, chk_mi);
    end
    if (chk_mi) chk(got == exp_mi, "R3 transmitted byte", got, exp_mi);
  endtask

  task automatic send_bits(input int n);
    for (int i = 0; i < n; i++) begin
      if (cpol) spi_sck = 1'b0;
      spi_mosi = i[0];
      wait_cyc(H);
      spi_sck = 1'b1;
      wait_cyc(H);
      if (!cpol) spi_sck = 1'b0;
    end
  endtask

  task automatic select();
    spi_sck = cpol;
    wait_cyc(H);
    spi_cs_n = 1'b0;
    wait_cyc(H);
  endtask

  task automatic deselect();
    wait_cyc(H);
    spi_cs_n = 1'b1;
    spi_sck = cpol;
    wait_cyc(2 * H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(4);
    chk(spi_miso_oe == 1'b0, "R4 reset driver off", spi_miso_oe, 0);
    chk(rx_valid == 1'b0, "R1 reset no byte", rx_valid, 0);
    chk(tx_ready == 1'b0, "R4 reset tx not ready", tx_ready, 0);
    chk(bit_cnt == 3'd0, "R2 reset count", bit_cnt, 0);

    // R5: select low since power-up is ignored
    send_bits(8);
    wait_cyc(H);
    chk(bit_cnt == 3'd0, "R5 count stays zero unarmed", bit_cnt, 0);
    chk(n_done == 0, "R5 no byte unarmed", n_done, 0);
    exp_done--;
    exp_done++;
    spi_cs_n = 1'b1;
    wait_cyc(2 * H);

    // mode (0,0) write-style burst
    select();
    xfer(8'h02, 1, 0, 8'h00, -1);
    xfer(8'h1F, 1, 0, 8'h00, -1);
    send_bits(0);
    chk(bit_cnt == 3'd0, "R2 count wraps after byte", bit_cnt, 0);
    chk(spi_miso_oe == 1'b0, "R3 no drive without data", spi_miso_oe, 0);
    xfer(8'h80, 1, 0, 8'h00, -1);
    deselect();

    // mode (0,0) read with a pause mid-byte
    tx_q.push_back(8'hA5);
    tx_q.push_back(8'h3C);
    select();
    xfer(8'h03, 1, 0, 8'h00, -1);
    xfer(8'h00, 1, 1, 8'hA5, 3);
    xfer(8'hFF, 1, 1, 8'h3C, -1);
    deselect();
    chk(spi_miso_oe == 1'b0, "R4 driver off after deselect", spi_miso_oe, 0);

    // mode (1,1) read with a pause requested while clock high
    cpol = 1'b1;
    tx_q.push_back(8'h96);
    select();
    xfer(8'h0B, 1, 0, 8'h00, -1);
    xfer(8'h44, 1, 1, 8'h96, 4);
    deselect();
    chk(tx_q.size() == 0, "R9 mode (1,1) byte consumed", tx_q.size(), 0);

    // R1 back-pressure: newer byte replaces waiting one
    cpol = 1'b0;
    @(posedge clk); #1 rx_ready = 1'b0;
    select();
    xfer(8'h11, 0, 0, 8'h00, -1);
    xfer(8'h22, 1, 0, 8'h00, -1);
    wait_cyc(H);
    chk(rx_valid == 1'b1, "R1 byte waiting", rx_valid, 1);
    chk(rx_data == 8'h22, "R1 newer byte kept", rx_data, 8'h22);
    deselect();
    @(posedge clk); #1 rx_ready = 1'b1;
    wait_cyc(4);

    // R8: deselect during a pause drops the partial byte
    select();
    send_bits(3);
    spi_hold_n = 1'b0;
    wait_cyc(H);
    chk(bit_cnt == 3'd3, "R8 partial count before drop", bit_cnt, 3);
    spi_cs_n = 1'b1;
    wait_cyc(H);
    chk(bit_cnt == 3'd0, "R8 count cleared", bit_cnt, 0);
    chk(spi_miso_oe == 1'b0, "R8 driver off", spi_miso_oe, 0);
    spi_hold_n = 1'b1;
    wait_cyc(H);
    select();
    xfer(8'h5A, 1, 0, 8'h00, -1);
    deselect();

    wait_cyc(H);
    chk(rx_q.size() == 0, "R1 all bytes delivered", rx_q.size(), 0);
    chk(n_done == exp_done, "R2 byte pulse count", n_done, exp_done);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule